// File: doc/BRIEF.md
# GPU L2 Line Coherence Controller

This block is the per-line control core of a shared second-level cache for a GPU. Each accepted event (read, write, atomic, replacement, invalidating probe, memory fill, memory write acknowledge or atomic-done trigger) is applied to the line's current state. The block then produces one result: a set of action strobes, an error flag and a latency tag for any message the actions send. The data arrays, the tag lookup and the network are outside the block. They act on the strobes. A static `wb_mode` pin chooses write-back (1) or write-through (0) handling of writes.

Events arrive on a valid/ready stream, and results leave on a second valid/ready stream. The result is registered, so it appears one cycle after the event is accepted. A new event is accepted only while the result slot is empty or being drained in the same cycle (`ev_ready = !res_valid || res_ready`). While `res_valid` is high and `res_ready` is low, the result holds steady. Whether the upstream queue should pop, recycle or keep the request at its head is given by the dequeue and recycle strobes, not by the handshake.

Encodings. State (`line_st`): I=0, V=1, W=2 (dirty, written), M=3 (modified), IV=4 (awaiting fill), WI=5 (awaiting write ack), A=6 (awaiting atomic data). Event codes (`ev_code`): read=0, write=1, atomic=2, replacement=3, probe=4, fill=5, write-ack=6, atomic-done=7; codes 8..15 are illegal. Action bits (`res_act`): 0 send data to core, 1 acknowledge to core, 2 forward request downstream (miss or atomic), 3 write through, 4 write back, 5 invalidate line, 6 allocate line, 7 touch MRU, 8 probe ack, 9 dequeue, 10 recycle, 11 unblock, 12 free tracker. An outstanding-atomics counter (CNT_W bits) belongs to state A.

Top module: `l2_line_ctrl`

## Requirements
- R1: After reset the state is I, no result is valid and `ev_ready` is 1.
- R2: Exactly one result follows each accepted event, one cycle later. The state changes only on an accepted event. A result that is not drained keeps its value, and `ev_ready` stays 0 until the result is drained.
- R3: Read: in M or V it sets {data, MRU, dequeue} and the state is kept. In W it sets {write back} and moves to WI without dequeue. In I it sets {forward, dequeue} and moves to IV. In IV it sets {dequeue} only (coalesced).
- R4: Recycle-only results (bit 10 alone): every read, write or atomic in WI; read or write in A; write or atomic in IV.
- R5: Write-through mode: a write in I sets {write through, dequeue} and stays I. In V it sets {MRU, write through, dequeue} and stays V. In M or W it is illegal.
- R6: Write-back mode: a write sets {ack, MRU, dequeue}. From I it adds allocate and goes to W. V or M go to M. W stays W.
- R7: Atomic: in V or I it sets {invalidate, forward, dequeue}, moves to A and sets the count to 1. In A it sets {forward, dequeue} and increments the count, or recycles when the count is at its maximum. In M or W it sets {write back} and moves to WI.
- R8: Probe always sets {probe ack, dequeue}. I and V go to I, M goes to W, and all other states are kept.
- R9: Replacement: in W or M it sets {write back, invalidate} and moves to WI. In I or V it sets {invalidate} and goes to I. In IV, WI or A it sets {invalidate} and keeps the state.
- R10: Fill: in IV it sets {allocate, MRU, data, unblock, dequeue, free} and goes to V. In A with a nonzero count it sets {allocate, data, unblock, dequeue}, decrements the count and stays in A.
- R11: Write ack: in I, V, IV or A it sets {ack, unblock, dequeue} and keeps the state. In WI it sets {unblock, free, dequeue} and goes to I.
- R12: Atomic-done in A sets {dequeue}. With a count of 0 it also sets free and goes to I; otherwise it stays in A.
- R13: Any event with no legal transition (codes 8..15, write ack in M/W, fill outside IV/A or in A with count 0, atomic-done outside A, write-through write in M/W) gives `res_err`=1, no action bits and no change of state or count.
- R14: `res_lat` is REQ_LAT (50) if any of forward, write through or write back is set. Otherwise it is RSP_LAT (20) if data or ack is set, otherwise 1 if probe ack or unblock is set, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through (static) |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_code | input | 4 | Event code |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_act | output | 13 | Action strobes |
| res_err | output | 1 | Illegal transition flag |
| res_lat | output | 6 | Latency tag in cycles |
| line_st | output | 3 | Current line state |

## Verification
Directed sequences in both modes take the line through every stable and transient state. These sequences separate the read, write and atomic handling of each state, the probe demotion of M to W, and the fill and acknowledge exits from IV and WI. A run of atomics up to the counter limit, followed by draining fills, shows the saturation recycle and the count-dependent atomic-done exit. Random event streams, with some illegal codes mixed in, are compared each cycle against a bench model of the transition table. This exposes wrong next states, missing or extra strobes, and error-flag leaks into the action bits. A stalled result test shows that back-pressure freezes both the result and the state.

// File: rtl/l2lc_pkg.sv
package l2lc_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_V = 3'd1, ST_W = 3'd2, ST_M = 3'd3,
    ST_IV = 3'd4, ST_WI = 3'd5, ST_A = 3'd6
  } lstate_e;

  localparam logic [3:0] EV_RD    = 4'd0;
  localparam logic [3:0] EV_WR    = 4'd1;
  localparam logic [3:0] EV_ATOM  = 4'd2;
  localparam logic [3:0] EV_REPL  = 4'd3;
  localparam logic [3:0] EV_PROBE = 4'd4;
  localparam logic [3:0] EV_FILL  = 4'd5;
  localparam logic [3:0] EV_WACK  = 4'd6;
  localparam logic [3:0] EV_ADONE = 4'd7;

  localparam int NACT    = 13;
  localparam int A_DATA  = 0;
  localparam int A_ACK   = 1;
  localparam int A_FWD   = 2;
  localparam int A_WTHRU = 3;
  localparam int A_WBACK = 4;
  localparam int A_INV   = 5;
  localparam int A_ALLOC = 6;
  localparam int A_MRU   = 7;
  localparam int A_PACK  = 8;
  localparam int A_DEQ   = 9;
  localparam int A_RECYC = 10;
  localparam int A_UNBLK = 11;
  localparam int A_FREE  = 12;
endpackage

// File: rtl/l2lc_xlate.sv
module l2lc_xlate
  import l2lc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  lstate_e          st,
  input  logic [CNT_W-1:0] cnt,
  input  logic [3:0]       code,
  input  logic             wbm,
  output lstate_e          nst,
  output logic [CNT_W-1:0] ncnt,
  output logic [NACT-1:0]  act,
  output logic             err
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_comb begin
    nst  = st;
    ncnt = cnt;
    act  = '0;
    err  = 1'b0;
    unique case (code)
      EV_RD: begin
        case (st)
          ST_M, ST_V: begin act[A_DATA] = 1'b1; act[A_MRU] = 1'b1; act[A_DEQ] = 1'b1; end
          ST_W:       begin act[A_WBACK] = 1'b1; nst = ST_WI; end
          ST_I:       begin act[A_FWD] = 1'b1; act[A_DEQ] = 1'b1; nst = ST_IV; end
          ST_IV:      act[A_DEQ] = 1'b1;
          ST_WI, ST_A: act[A_RECYC] = 1'b1;
          default:    err = 1'b1;
        endcase
      end
      EV_WR: begin
        if (st == ST_IV || st == ST_WI || st == ST_A) begin
          act[A_RECYC] = 1'b1;
        end else if (wbm) begin
          act[A_ACK] = 1'b1; act[A_MRU] = 1'b1; act[A_DEQ] = 1'b1;
          case (st)
            ST_I:       begin act[A_ALLOC] = 1'b1; nst = ST_W; end
            ST_V, ST_M: nst = ST_M;
            ST_W:       nst = ST_W;
            default:    err = 1'b1;
          endcase
        end else begin
          case (st)
            ST_I:    begin act[A_WTHRU] = 1'b1; act[A_DEQ] = 1'b1; end
            ST_V:    begin act[A_MRU] = 1'b1; act[A_WTHRU] = 1'b1; act[A_DEQ] = 1'b1; end
            default: err = 1'b1;
          endcase
        end
      end
      EV_ATOM: begin
        case (st)
          ST_IV, ST_WI: act[A_RECYC] = 1'b1;
          ST_A: begin
            if (cnt == CMAX) act[A_RECYC] = 1'b1;
            else begin act[A_FWD] = 1'b1; act[A_DEQ] = 1'b1; ncnt = cnt + 1'b1; end
          end
          ST_V, ST_I: begin
            act[A_INV] = 1'b1; act[A_FWD] = 1'b1; act[A_DEQ] = 1'b1;
            nst = ST_A; ncnt = CNT_W'(1);
          end
          ST_M, ST_W: begin act[A_WBACK] = 1'b1; nst = ST_WI; end
          default: err = 1'b1;
        endcase
      end
      EV_REPL: begin
        case (st)
          ST_W, ST_M: begin act[A_WBACK] = 1'b1; act[A_INV] = 1'b1; nst = ST_WI; end
          ST_I, ST_V: begin act[A_INV] = 1'b1; nst = ST_I; end
          ST_IV, ST_WI, ST_A: act[A_INV] = 1'b1;
          default: err = 1'b1;
        endcase
      end
      EV_PROBE: begin
        act[A_PACK] = 1'b1; act[A_DEQ] = 1'b1;
        case (st)
          ST_I, ST_V: nst = ST_I;
          ST_M:       nst = ST_W;
          ST_W, ST_IV, ST_WI, ST_A: nst = st;
          default:    err = 1'b1;
        endcase
      end
      EV_FILL: begin
        case (st)
          ST_IV: begin
            act[A_ALLOC] = 1'b1; act[A_MRU] = 1'b1; act[A_DATA] = 1'b1;
            act[A_UNBLK] = 1'b1; act[A_DEQ] = 1'b1; act[A_FREE] = 1'b1;
            nst = ST_V;
          end
          ST_A: begin
            if (cnt == '0) err = 1'b1;
            else begin
              act[A_ALLOC] = 1'b1; act[A_DATA] = 1'b1;
              act[A_UNBLK] = 1'b1; act[A_DEQ] = 1'b1;
              ncnt = cnt - 1'b1;
            end
          end
          default: err = 1'b1;
        endcase
      end
      EV_WACK: begin
        case (st)
          ST_I, ST_V, ST_IV, ST_A: begin
            act[A_ACK] = 1'b1; act[A_UNBLK] = 1'b1; act[A_DEQ] = 1'b1;
          end
          ST_WI: begin
            act[A_UNBLK] = 1'b1; act[A_FREE] = 1'b1; act[A_DEQ] = 1'b1; nst = ST_I;
          end
          default: err = 1'b1;
        endcase
      end
      EV_ADONE: begin
        if (st == ST_A) begin
          act[A_DEQ] = 1'b1;
          if (cnt == '0) begin act[A_FREE] = 1'b1; nst = ST_I; end
        end else begin
          err = 1'b1;
        end
      end
      default: err = 1'b1;
    endcase
    if (err) begin
      nst  = st;
      ncnt = cnt;
      act  = '0;
    end
  end
endmodule

// File: rtl/l2lc_lat.sv
module l2lc_lat
  import l2lc_pkg::*;
#(
  parameter int REQ_LAT = 50,
  parameter int RSP_LAT = 20,
  parameter int LAT_W   = 6
) (
  input  logic [NACT-1:0]  act,
  output logic [LAT_W-1:0] lat
);
  always_comb begin
    if (act[A_FWD] | act[A_WTHRU] | act[A_WBACK]) lat = LAT_W'(REQ_LAT);
    else if (act[A_DATA] | act[A_ACK])            lat = LAT_W'(RSP_LAT);
    else if (act[A_PACK] | act[A_UNBLK])          lat = LAT_W'(1);
    else                                          lat = '0;
  end
endmodule

// File: rtl/l2lc_oreg.sv
module l2lc_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !drain) |=> (valid && $stable(q))); // R2
endmodule

// File: rtl/l2_line_ctrl.sv
module l2_line_ctrl
  import l2lc_pkg::*;
#(
  parameter int REQ_LAT = 50,
  parameter int RSP_LAT = 20,
  parameter int CNT_W   = 3,
  localparam int LAT_W  = $clog2(((REQ_LAT > RSP_LAT) ? REQ_LAT : RSP_LAT) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_mode,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [3:0]       ev_code,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [NACT-1:0]  res_act,
  output logic             res_err,
  output logic [LAT_W-1:0] res_lat,
  output logic [2:0]       line_st
);
  localparam int RW = NACT + 1 + LAT_W;

  lstate_e          state, nst;
  logic [CNT_W-1:0] cnt, ncnt;
  logic [NACT-1:0]  act;
  logic             err;
  logic [LAT_W-1:0] lat;
  logic             fire;

  assign ev_ready = !res_valid || res_ready;
  assign fire     = ev_valid && ev_ready;
  assign line_st  = state;

  l2lc_xlate #(.CNT_W(CNT_W)) u_xlate (
    .st(state), .cnt(cnt), .code(ev_code), .wbm(wb_mode),
    .nst(nst), .ncnt(ncnt), .act(act), .err(err)
  );

  l2lc_lat #(.REQ_LAT(REQ_LAT), .RSP_LAT(RSP_LAT), .LAT_W(LAT_W)) u_lat (
    .act(act), .lat(lat)
  );

  l2lc_oreg #(.W(RW)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(fire), .drain(res_ready),
    .d({err, lat, act}), .valid(res_valid), .q({res_err, res_lat, res_act})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_I;
      cnt   <= '0;
    end else if (fire) begin
      state <= nst;
      cnt   <= ncnt;
    end
  end

  AST_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(state)); // R2
  AST_PROBE_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state == ST_M && ev_code == EV_PROBE) |=> state == ST_W); // R8
  AST_WT_STAY_I: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wb_mode && state == ST_I && ev_code == EV_WR) |=> state == ST_I); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> res_act == '0); // R13
  AST_DEQ_OR_RECYC: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_act[A_DEQ] && res_act[A_RECYC])); // R4
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_A) |-> cnt == '0); // R7
endmodule

// File: tb/l2_line_ctrl_test.sv
module l2_line_ctrl_test;
  localparam int LW = 6;
  localparam int CMAXV = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_mode = 1'b0;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic [3:0] ev_code = 4'd0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [12:0] res_act;
  logic res_err;
  logic [LW-1:0] res_lat;
  logic [2:0] line_st;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [2:0] m_st = 3'd0;
  int m_cnt = 0;

  l2_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_code(ev_code), .res_valid(res_valid),
    .res_ready(res_ready), .res_act(res_act), .res_err(res_err),
    .res_lat(res_lat), .line_st(line_st)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] bits(input int b0, input int b1 = -1, input int b2 = -1,
                                       input int b3 = -1, input int b4 = -1, input int b5 = -1);
    logic [12:0] v = '0;
    if (b0 >= 0) v[b0] = 1'b1;
    if (b1 >= 0) v[b1] = 1'b1;
    if (b2 >= 0) v[b2] = 1'b1;
    if (b3 >= 0) v[b3] = 1'b1;
    if (b4 >= 0) v[b4] = 1'b1;
    if (b5 >= 0) v[b5] = 1'b1;
    return v;
  endfunction

  // state codes I0 V1 W2 M3 IV4 WI5 A6; bits per brief
  task automatic model(input logic [2:0] s, input int n, input logic [3:0] c, input bit wb,
                       output logic [2:0] ns, output int nn, output logic [12:0] a, output bit e);
    ns = s; nn = n; a = '0; e = 0;
    case (c)
      4'd0: begin // R3 / R4
        if (s == 3 || s == 1) a = bits(0, 7, 9);
        else if (s == 2) begin a = bits(4); ns = 5; end
        else if (s == 0) begin a = bits(2, 9); ns = 4; end
        else if (s == 4) a = bits(9);
        else a = bits(10);
      end
      4'd1: begin // R4 R5 R6
        if (s >= 4) a = bits(10);
        else if (wb) begin
          a = bits(1, 7, 9);
          if (s == 0) begin a[6] = 1'b1; ns = 2; end
          else if (s == 2) ns = 2;
          else ns = 3;
        end else if (s == 0) a = bits(3, 9);
        else if (s == 1) a = bits(7, 3, 9);
        else e = 1;
      end
      4'd2: begin // R7
        if (s == 4 || s == 5) a = bits(10);
        else if (s == 6) begin
          if (n == CMAXV) a = bits(10);
          else begin a = bits(2, 9); nn = n + 1; end
        end else if (s == 0 || s == 1) begin a = bits(5, 2, 9); ns = 6; nn = 1; end
        else begin a = bits(4); ns = 5; end
      end
      4'd3: begin // R9
        if (s == 2 || s == 3) begin a = bits(4, 5); ns = 5; end
        else if (s <= 1) begin a = bits(5); ns = 0; end
        else a = bits(5);
      end
      4'd4: begin // R8
        a = bits(8, 9);
        if (s <= 1) ns = 0; else if (s == 3) ns = 2;
      end
      4'd5: begin // R10
        if (s == 4) begin a = bits(6, 7, 0, 11, 9, 12); ns = 1; end
        else if (s == 6 && n > 0) begin a = bits(6, 0, 11, 9); nn = n - 1; end
        else e = 1;
      end
      4'd6: begin // R11
        if (s == 5) begin a = bits(11, 12, 9); ns = 0; end
        else if (s == 2 || s == 3) e = 1;
        else a = bits(1, 11, 9);
      end
      4'd7: begin // R12
        if (s == 6) begin
          a = bits(9);
          if (n == 0) begin a[12] = 1'b1; ns = 0; end
        end else e = 1;
      end
      default: e = 1;
    endcase
    if (e) begin ns = s; nn = n; a = '0; end
  endtask

  function automatic string tag_of(input logic [3:0] c, input bit e, input logic [12:0] a, input bit wb);
    if (e) return "R13";
    if (a == bits(10)) return "R4";
    case (c)
      4'd0: return "R3";
      4'd1: return wb ? "R6" : "R5";
      4'd2: return "R7";
      4'd3: return "R9";
      4'd4: return "R8";
      4'd5: return "R10";
      4'd6: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [LW-1:0] lat_of(input logic [12:0] a); // R14
    if (a[2] | a[3] | a[4]) return LW'(50);
    if (a[0] | a[1]) return LW'(20);
    if (a[8] | a[11]) return LW'(1);
    return '0;
  endfunction

  task automatic send(input logic [3:0] c);
    logic [2:0] ns; int nn; logic [12:0] a; bit e; string t;
    @(negedge clk);
    ev_valid = 1'b1; ev_code = c; res_ready = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    model(m_st, m_cnt, c, wb_mode, ns, nn, a, e);
    t = tag_of(c, e, a, wb_mode);
    chk({t, " result"}, {17'd0, res_valid, res_err, res_act}, {17'd0, 1'b1, e, a});
    chk({t, " state"}, {29'd0, line_st}, {29'd0, ns});
    chk("R14 latency", {26'd0, res_lat}, {26'd0, lat_of(a)});
    m_st = ns; m_cnt = nn;
  endtask

  task automatic do_reset(input bit wb);
    @(negedge clk);
    rst_n = 1'b0; wb_mode = wb; ev_valid = 1'b0; res_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_st = 3'd0; m_cnt = 0;
    @(negedge clk);
    chk("R1 reset", {29'd0, line_st, res_valid, ev_ready}, {29'd0, 3'd0, 1'b0, 1'b1});
  endtask

  initial begin
    logic [12:0] held;
    logic [3:0] c;
    void'($urandom(32'd4242));
    // write-through phase
    do_reset(1'b0);
    send(4'd0); send(4'd0); send(4'd1); send(4'd2); // I->IV, coalesce, recycle x2
    send(4'd5); send(4'd0); send(4'd1);               // fill->V, hit, WT merge
    send(4'd4); send(4'd1);                           // probe V->I, WT write stays I
    send(4'd2); send(4'd0); send(4'd1);               // atomic ->A, recycles
    for (int i = 0; i < 8; i++) send(4'd2);           // count to max, last recycles
    send(4'd7);                                       // done with count nonzero
    for (int i = 0; i < CMAXV; i++) send(4'd5);       // drain
    send(4'd5); send(4'd7);                           // fill at 0 illegal; done ->I
    send(4'd6); send(4'd9); send(4'd3);
    // R2 back-pressure
    @(negedge clk);
    ev_valid = 1'b1; ev_code = 4'd0; res_ready = 1'b0;
    @(negedge clk);
    ev_code = 4'd5; held = res_act;
    model(m_st, m_cnt, 4'd0, 1'b0, m_st, m_cnt, held, held[0]);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 stall", {16'd0, ev_ready, res_valid, line_st, res_act},
          {16'd0, 1'b0, 1'b1, 3'd4, bits(2, 9)});
    end
    ev_valid = 1'b0; res_ready = 1'b1;
    @(negedge clk);
    chk("R2 drain", {31'd0, res_valid}, 32'd0);
    for (int i = 0; i < 300; i++) begin
      c = 4'($urandom % 9);
      if (c == 4'd8) c = 4'(8 + $urandom % 8);
      send(c);
    end
    // write-back phase
    do_reset(1'b1);
    send(4'd1); send(4'd4); send(4'd1); send(4'd0);   // I->W, probe keeps W, W, read->WI
    send(4'd1); send(4'd6); send(4'd0); send(4'd5);   // recycle, ack->I, miss, fill->V
    send(4'd1); send(4'd4); send(4'd6); send(4'd3);   // V->M, M->W, ack in W illegal, repl->WI
    send(4'd6); send(4'd0); send(4'd5); send(4'd1);
    send(4'd2); send(4'd6);                           // atomic in M -> WI, ack
    for (int i = 0; i < 300; i++) begin
      c = 4'($urandom % 9);
      if (c == 4'd8) c = 4'(8 + $urandom % 8);
      send(c);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule